// File: doc/BRIEF.md
# Breakpoint Segment Lookup

This block keeps a short table of breakpoint pairs, each pair holding an abscissa `x` and an ordinate `y`. A caller presents a 3-bit value with a one-cycle strobe. The block then works out which segment of the table the value falls into. It returns the index of that segment, along with the wrapped sum of the chosen entry's `x` and `y`, under a one-cycle result strobe. The table is not written at run time. A synchronous reset fills it from parameter formulas, so entry `i` holds `x = X_BASE + i*X_STEP` and `y = Y_BASE + i*Y_STEP`. The default values give the three pairs (0,0), (1,1) and (2,2).

The search does not compare the input against every entry at once. It is a small state machine that visits one entry per clock, starting at index 0, so the logic between flops stays one comparator deep however many entries the table has. Every request takes the same number of cycles. The caller waits while `busy` is high and may issue the next request in the same cycle that the previous result appears.

Top module: `bp_seg_lookup`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `out_valid` and `busy` are 0.
- R2: At reset, entry `i` (0 to DEPTH-1) is loaded with `x = (X_BASE + i*X_STEP) mod 8` and `y = (Y_BASE + i*Y_STEP) mod 8`. It is kept as one 6-bit word with `y` in the upper 3 bits and `x` in the lower 3 bits, and it does not change until the next reset.
- R3: Entries are examined in ascending index order, starting at 0. The reported `seg_idx` is the highest index whose `x` is less than or equal to the sampled input. It always lies between 0 and DEPTH-1.
- R4: If the input is below the `x` of every entry, `seg_idx` is 0.
- R5: `result` is the sum of the selected entry's `x` and `y`, truncated to 3 bits (modulo 8).
- R6: A request is accepted at a clock edge where `in_valid` is 1 and `busy` is 0. `out_valid` is then 1 for exactly one cycle, namely the cycle after the edge DEPTH+1 edges later.
- R7: `in_valid` is ignored while `busy` is 1. It produces no extra result and does not change the result of the request in progress.
- R8: `busy` is 1 from the accepting edge until the cycle in which `out_valid` is 1. It is 0 in that cycle, so a new request can be accepted there.
- R9: A reset during a search abandons it, and no result is delivered for that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the table |
| in_valid | input | 1 | Request strobe |
| in_x | input | XW (3) | Value to locate |
| busy | output | 1 | Search in progress; requests ignored |
| out_valid | output | 1 | One-cycle result strobe |
| seg_idx | output | $clog2(DEPTH) | Selected segment index |
| result | output | XW (3) | Wrapped x + y of the selected entry |

## Verification
The assertions watch, on every cycle, the properties that do not depend on data values:
- the one-cycle result pulse,
- the fixed scan length ending in the done state,
- the sampled key holding steady while the block is busy,
- the index staying inside the table,
- the table holding its contents between resets.

Only the bench scenarios can show the data-dependent and sequence-dependent behaviour. It uses a non-default table, so it can exercise inputs below the first breakpoint, matches on exact breakpoints, inputs above the last one, and sums that wrap past 7. The same scenarios measure the exact latency in cycles, confirm that requests raised while busy are dropped, confirm that a request can follow back-to-back in the result cycle, and check that a reset in the middle of a search yields no result.

// File: rtl/bp_lookup_pkg.sv
// Package: shared state encoding for the breakpoint segment lookup.
// Assumes nothing beyond being compiled first.
package bp_lookup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;

endpackage

// File: rtl/bp_table.sv
// Module: bp_table
// Holds DEPTH breakpoint words, each packing y in the upper YW bits and x in
// the lower XW bits. The contents come from parameter formulas while rst_n is
// low and otherwise never change. There are two combinational read ports: one
// for the scanning pointer and one for the selected entry.
// Assumes: DEPTH >= 2; select values beyond DEPTH-1 read as zero.
module bp_table #(
    parameter int unsigned DEPTH  = 3,
    parameter int unsigned XW     = 3,
    parameter int unsigned YW     = 3,
    parameter int unsigned X_BASE = 0,
    parameter int unsigned X_STEP = 1,
    parameter int unsigned Y_BASE = 0,
    parameter int unsigned Y_STEP = 1,
    parameter int unsigned IW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] scan_sel,
    input  logic [IW-1:0] pick_sel,
    output logic [XW-1:0] scan_x,
    output logic [XW-1:0] pick_x,
    output logic [YW-1:0] pick_y
);

    localparam int unsigned EW = XW + YW;

    logic [EW-1:0] entry_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int unsigned DX = (X_BASE + i * X_STEP) % (2 ** XW);
        localparam int unsigned DY = (Y_BASE + i * Y_STEP) % (2 ** YW);

        // Load the default pair during reset; hold it otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[i] <= {YW'(DY), XW'(DX)};
            end
        end

        AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(entry_q[i])); // R2
    end

    // Read port for the entry under scan.
    always_comb begin
        scan_x = '0;
        if (32'(scan_sel) < DEPTH) begin
            scan_x = entry_q[scan_sel][XW-1:0];
        end
    end

    // Read port for the selected entry.
    always_comb begin
        pick_x = '0;
        pick_y = '0;
        if (32'(pick_sel) < DEPTH) begin
            pick_x = entry_q[pick_sel][XW-1:0];
            pick_y = entry_q[pick_sel][EW-1:XW];
        end
    end

endmodule

// File: rtl/bp_scan_fsm.sv
// Module: bp_scan_fsm
// Accepts a key in IDLE. It then visits entries 0..DEPTH-1, one per clock,
// and remembers the last index whose x does not exceed the key (index 0 if
// none does). After that it spends one cycle in DONE. The scan always runs
// the full length of the table, so the latency is fixed.
// Assumes: table x values ascend with index for the "segment" meaning to hold.
module bp_scan_fsm
    import bp_lookup_pkg::*;
#(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned XW    = 3,
    parameter int unsigned IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [XW-1:0] in_x,
    input  logic [XW-1:0] scan_x,
    output logic [IW-1:0] scan_sel,
    output logic [IW-1:0] best_idx,
    output logic          scan_done,
    output logic          busy
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    scan_state_t   state_q;
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] best_q;
    logic [XW-1:0] key_q;

    // State, pointer, key and best-match registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            best_q  <= '0;
            key_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        key_q   <= in_x;
                        ptr_q   <= '0;
                        best_q  <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (scan_x <= key_q) begin
                        best_q <= ptr_q;
                    end
                    if (ptr_q == LAST) begin
                        state_q <= ST_DONE;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status decode for the neighbours.
    always_comb begin
        scan_sel  = ptr_q;
        best_idx  = best_q;
        scan_done = (state_q == ST_DONE);
        busy      = (state_q != ST_IDLE);
    end

    AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(key_q)); // R7
    AST_SCAN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && ptr_q == LAST) |=> (state_q == ST_DONE)); // R6
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (ptr_q <= LAST)); // R3
    AST_DONE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE)); // R8

endmodule

// File: rtl/bp_result.sv
// Module: bp_result
// Registers the outcome of a scan: the chosen index and the wrapped x + y sum.
// It raises out_valid for the single cycle after the load strobe.
// Assumes: YW <= XW; the sum is truncated to XW bits.
module bp_result #(
    parameter int unsigned XW = 3,
    parameter int unsigned YW = 3,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] pick_idx,
    input  logic [XW-1:0] pick_x,
    input  logic [YW-1:0] pick_y,
    output logic          out_valid,
    output logic [IW-1:0] seg_idx,
    output logic [XW-1:0] result
);

    // Output registers: strobe every cycle, data only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            seg_idx   <= '0;
            result    <= '0;
        end else begin
            out_valid <= load;
            if (load) begin
                seg_idx <= pick_idx;
                result  <= pick_x + XW'(pick_y);
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6
    AST_LOAD_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_valid); // R6

endmodule

// File: rtl/bp_seg_lookup.sv
// Module: bp_seg_lookup (top)
// Breakpoint segment lookup. A request strobe samples in_x. A scan machine
// walks the reset-loaded table one entry per clock, and the result stage
// reports the segment index and the wrapped x + y of that entry DEPTH+1
// edges after acceptance.
// Assumes: DEPTH >= 2, YW <= XW, synchronous active-low reset.
module bp_seg_lookup #(
    parameter int unsigned DEPTH  = 3,
    parameter int unsigned XW     = 3,
    parameter int unsigned YW     = 3,
    parameter int unsigned X_BASE = 0,
    parameter int unsigned X_STEP = 1,
    parameter int unsigned Y_BASE = 0,
    parameter int unsigned Y_STEP = 1,
    localparam int unsigned IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [XW-1:0] in_x,
    output logic          busy,
    output logic          out_valid,
    output logic [IW-1:0] seg_idx,
    output logic [XW-1:0] result
);

    logic [IW-1:0] scan_sel;
    logic [IW-1:0] best_idx;
    logic [XW-1:0] scan_x;
    logic [XW-1:0] pick_x;
    logic [YW-1:0] pick_y;
    logic          scan_done;

    bp_table #(
        .DEPTH(DEPTH), .XW(XW), .YW(YW),
        .X_BASE(X_BASE), .X_STEP(X_STEP),
        .Y_BASE(Y_BASE), .Y_STEP(Y_STEP), .IW(IW)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .scan_sel(scan_sel), .pick_sel(best_idx),
        .scan_x(scan_x), .pick_x(pick_x), .pick_y(pick_y)
    );

    bp_scan_fsm #(.DEPTH(DEPTH), .XW(XW), .IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_x(in_x), .scan_x(scan_x),
        .scan_sel(scan_sel), .best_idx(best_idx),
        .scan_done(scan_done), .busy(busy)
    );

    bp_result #(.XW(XW), .YW(YW), .IW(IW)) u_result (
        .clk(clk), .rst_n(rst_n),
        .load(scan_done), .pick_idx(best_idx),
        .pick_x(pick_x), .pick_y(pick_y),
        .out_valid(out_valid), .seg_idx(seg_idx), .result(result)
    );

    AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(seg_idx) < DEPTH)); // R3
    AST_IDLE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !busy); // R8

endmodule

// File: tb/tb_bp_seg_lookup.sv
`timescale 1ns/1ps
module tb_bp_seg_lookup;

    localparam int DEPTH = 5;
    localparam int XB = 2, XS = 1, YB = 3, YS = 2;
    localparam int IW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [2:0]    in_x;
    logic          busy;
    logic          out_valid;
    logic [IW-1:0] seg_idx;
    logic [2:0]    result;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int q_idx[$];
    int q_res[$];
    int q_cyc[$];

    bp_seg_lookup #(
        .DEPTH(DEPTH), .XW(3), .YW(3),
        .X_BASE(XB), .X_STEP(XS), .Y_BASE(YB), .Y_STEP(YS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .busy(busy), .out_valid(out_valid), .seg_idx(seg_idx), .result(result)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int ex(input int i);
        return (XB + i * XS) % 8;
    endfunction

    function automatic int ey(input int i);
        return (YB + i * YS) % 8;
    endfunction

    // Model of R3/R4: highest index with x <= v, else 0.
    function automatic int model_idx(input int v);
        int best = 0;
        for (int i = 0; i < DEPTH; i++) if (ex(i) <= v) best = i;
        return best;
    endfunction

    // Driver: waits for idle, issues one request, optionally records the expectation.
    task automatic send(input int v, input bit push);
        @(negedge clk);
        while (busy) @(negedge clk);
        in_valid = 1'b1;
        in_x = 3'(v);
        @(posedge clk);
        #1;
        if (push) begin
            q_idx.push_back(model_idx(v));
            q_res.push_back((ex(model_idx(v)) + ey(model_idx(v))) % 8);
            q_cyc.push_back(cyc + DEPTH + 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compares each result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && q_cyc.size() > 0 && cyc > q_cyc[0]) begin
            chk(1'b0, "R6 result missing", cyc, q_cyc[0]);
            void'(q_idx.pop_front());
            void'(q_res.pop_front());
            void'(q_cyc.pop_front());
        end
        if (rst_n && out_valid) begin
            if (q_cyc.size() == 0) begin
                chk(1'b0, "R7/R9 unexpected out_valid", 1, 0);
            end else begin
                chk(int'(seg_idx) == q_idx[0], "R3/R4 seg_idx", int'(seg_idx), q_idx[0]);
                chk(int'(result) == q_res[0], "R5 result", int'(result), q_res[0]);
                chk(cyc == q_cyc[0], "R6 latency", cyc, q_cyc[0]);
                void'(q_idx.pop_front());
                void'(q_res.pop_front());
                void'(q_cyc.pop_front());
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_x = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: sweep every input; 0,1 lie below x0, 3,4,6,7 wrap.
        for (int v = 0; v < 8; v++) send(v, 1'b1);
        // Back-to-back ordering the other way.
        for (int v = 7; v >= 0; v -= 3) send(v, 1'b1);

        // R7 and R8: strobes while busy are dropped.
        @(negedge clk);
        while (busy || q_cyc.size() > 0) @(negedge clk);
        in_valid = 1'b1;
        in_x = 3'd0;
        @(posedge clk);
        #1;
        q_idx.push_back(model_idx(0));
        q_res.push_back((ex(model_idx(0)) + ey(model_idx(0))) % 8);
        q_cyc.push_back(cyc + DEPTH + 1);
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        in_x = 3'd7;
        repeat (DEPTH - 1) @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        chk(busy == 1'b0, "R8 busy low with out_valid", int'(busy), 0);
        repeat (DEPTH + 3) @(negedge clk);
        chk(q_cyc.size() == 0, "R7 no pending result", q_cyc.size(), 0);

        // R9: reset in the middle of a search.
        send(5, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset edge", int'(busy), 0);
        rst_n = 1'b1;
        for (int k = 0; k < DEPTH + 3; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 aborted search silent", int'(out_valid), 0);
        end
        // R2: table intact after a second reset.
        send(6, 1'b1);
        send(2, 1'b1);

        repeat (DEPTH + 4) @(negedge clk);
        chk(q_cyc.size() == 0, "R6 all results delivered", q_cyc.size(), 0);
        summary();
        $finish;
    end

endmodule